// File: doc/BRIEF.md
# RV32I Datapath Control Decoder

This block turns one 32-bit RV32I instruction word into the control word that steers a single-cycle integer datapath. It is purely combinational. The control word covers the register-file write enable, the writeback source, the data-memory write enable and access kind, the ALU operation, the two ALU operand selects, the base of the PC-target adder, a next-PC hint and the immediate format. It decodes opcode, funct3 and funct7 for the whole base integer set apart from fence, ecall, ebreak and CSR accesses. Any other encoding raises an illegal-instruction flag.

The ALU has explicit operand-pass operations. Operand A has its own PC/rs1 select, and the PC-target adder has a separate base select. Because of this, lui, auipc and jalr are handled by plain control values and need no special datapath paths. Branch conditions are not resolved here. The hint only marks a branch as conditional, and a separate branch unit decides whether it is taken, using funct3 from the same word.

Top module: `rvdec_top`

## Requirements
- R1: Only these opcodes are recognised:
  - 0110011: register-register
  - 0010011: immediate ALU
  - 0000011: load
  - 0100011: store
  - 1100011: branch
  - 1101111: jal
  - 1100111: jalr
  - 0110111: lui
  - 0010111: auipc
  
  Any other opcode drives illegal_o high.
- R2: Register-register ALU codes are as follows.
  - funct7 0000000: alu_op_o equals {0, funct3}, giving add 0, sll 1, slt 2, sltu 3, xor 4, srl 5, or 6, and 7.
  - funct7 0100000 with funct3 000: subtract, code 8.
  - funct7 0100000 with funct3 101: arithmetic right shift, code 9.
- R3: Immediate ALU codes are as follows.
  - funct3 001 (left shift) and 101 (right shift) select imm_fmt_o = 1 (shift format).
  - For funct3 101, funct7 0100000 gives code 9; otherwise the code is {0, funct3}.
  - funct3 000 always gives add (0), never subtract.
  - All other funct3 values select imm_fmt_o = 0.
- R4: The following combinations drive illegal_o high:
  - a register-register funct7 other than the two legal values, or funct7 0100000 outside funct3 000/101;
  - a shift-immediate funct7 that is not legal for its shift;
  - load funct3 011, 110 or 111;
  - store funct3 above 010;
  - branch funct3 010 or 011;
  - jalr funct3 other than 000.
  
  On an illegal word every other output is 0.
- R5: wb_sel_o is 0 for the ALU result (register, immediate, lui and auipc ops), 1 for memory read data (loads) and 2 for PC+4 (jal and jalr).
- R6: For loads and stores, mem_kind_o equals funct3: 000 byte, 001 half, 010 word, 100 byte-unsigned, 101 half-unsigned. For other instructions it is 0.
- R7: reg_we_o is high for every legal instruction except stores and branches. mem_we_o is high only for legal stores.
- R8: For lui, alu_op_o is 11 (pass operand B) with opb_imm_o = 1. For auipc, opa_pc_o = 1, opb_imm_o = 1 and alu_op_o = 0 (add). Loads, stores and immediate ALU ops set opb_imm_o = 1.
- R9: tgt_rs1_o is 1 only for jalr, so branches and jal add to the PC. pc_sel_o is 0 for sequential, 1 for an unconditional jump (jal, jalr) and 2 for a conditional branch.
- R10: imm_fmt_o uses these codes: 0 I-arith, 1 I-shift, 2 S, 3 B, 4 J, 5 U. Stores use 2, branches 3, jal 4, and lui/auipc 5. Loads and jalr use 0.
- R11: Any output that a legal instruction does not use is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| reg_we_o | output | 1 | Register-file write enable |
| wb_sel_o | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC+4 |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_kind_o | output | 3 | Memory access kind (funct3 coding) |
| alu_op_o | output | 4 | ALU operation code |
| opa_pc_o | output | 1 | ALU operand A: 0 rs1, 1 PC |
| opb_imm_o | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| tgt_rs1_o | output | 1 | PC-target adder base: 0 PC, 1 rs1 |
| pc_sel_o | output | 2 | Next-PC hint: 0 sequential, 1 jump, 2 branch |
| imm_fmt_o | output | 3 | Immediate format select |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The checks assume that insn_i holds a settled 32-bit word without X or Z bits, and that the outputs are read only after the combinational logic has settled. The bench changes the word once per clock and samples on the opposite edge. The register-index fields play no part in decoding, so the sweep fills them with varying patterns that keep them fully defined. It covers every opcode with every funct3 against a set of funct7 values, and that set includes both legal values and several illegal neighbours.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int ILEN  = 32;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int F7_W  = 7;
  localparam int ALU_W = 4;
  localparam int IMM_W = 3;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    CL_NONE, CL_REG, CL_IMM, CL_LOAD, CL_STORE,
    CL_BRANCH, CL_JAL, CL_JALR, CL_LUI, CL_AUIPC
  } op_class_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SLL = 4'd1, ALU_SLT = 4'd2, ALU_SLTU = 4'd3,
    ALU_XOR = 4'd4, ALU_SRL = 4'd5, ALU_OR = 4'd6, ALU_AND = 4'd7,
    ALU_SUB = 4'd8, ALU_SRA = 4'd9, ALU_PASSA = 4'd10, ALU_PASSB = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2
  } wb_sel_e;

  typedef enum logic [1:0] {
    PCS_SEQ = 2'd0, PCS_JUMP = 2'd1, PCS_BRANCH = 2'd2
  } pc_sel_e;

  typedef enum logic [IMM_W-1:0] {
    IMF_IARITH = 3'd0, IMF_ISHIFT = 3'd1, IMF_S = 3'd2,
    IMF_B = 3'd3, IMF_J = 3'd4, IMF_U = 3'd5
  } imm_fmt_e;

  typedef struct packed {
    logic             reg_we;
    wb_sel_e          wb_sel;
    logic             mem_we;
    logic [F3_W-1:0]  mem_kind;
    alu_op_e          alu_op;
    logic             opa_pc;
    logic             opb_imm;
    logic             tgt_rs1;
    pc_sel_e          pc_sel;
    imm_fmt_e         imm_fmt;
  } ctrl_t;
endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output op_class_e        cls_o
);
  always_comb begin
    unique case (opc_i)
      OPC_REG:    cls_o = CL_REG;
      OPC_IMM:    cls_o = CL_IMM;
      OPC_LOAD:   cls_o = CL_LOAD;
      OPC_STORE:  cls_o = CL_STORE;
      OPC_BRANCH: cls_o = CL_BRANCH;
      OPC_JAL:    cls_o = CL_JAL;
      OPC_JALR:   cls_o = CL_JALR;
      OPC_LUI:    cls_o = CL_LUI;
      OPC_AUIPC:  cls_o = CL_AUIPC;
      default:    cls_o = CL_NONE;
    endcase
  end
endmodule

// File: rtl/rvdec_alu.sv
module rvdec_alu
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] f3_i,
  input  logic [F7_W-1:0] f7_i,
  input  logic            is_reg_i,
  output alu_op_e         op_o,
  output logic            legal_o,
  output logic            shift_fmt_o
);
  logic f7_base, f7_alt, is_srx, is_sll, alt_slot;

  assign f7_base  = (f7_i == F7_BASE);
  assign f7_alt   = (f7_i == F7_ALT);
  assign is_sll   = (f3_i == 3'b001);
  assign is_srx   = (f3_i == 3'b101);
  assign alt_slot = (f3_i == 3'b000) | is_srx;

  always_comb begin
    op_o        = alu_op_e'({1'b0, f3_i});
    legal_o     = 1'b1;
    shift_fmt_o = 1'b0;
    if (is_reg_i) begin
      legal_o = f7_base | (f7_alt & alt_slot);
      if (f7_alt) op_o = is_srx ? ALU_SRA : ALU_SUB;
    end else begin
      shift_fmt_o = is_sll | is_srx;
      if (is_sll) legal_o = f7_base;
      else if (is_srx) begin
        legal_o = f7_base | f7_alt;
        if (f7_alt) op_o = ALU_SRA;
      end
    end
  end
endmodule

// File: rtl/rvdec_mem.sv
module rvdec_mem
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] f3_i,
  input  logic            is_store_i,
  output logic [F3_W-1:0] kind_o,
  output logic            legal_o
);
  assign kind_o = f3_i;

  always_comb begin
    if (is_store_i) legal_o = (f3_i[2] == 1'b0) & (f3_i[1:0] != 2'b11);
    else            legal_o = (f3_i != 3'b011) & (f3_i[2:1] != 2'b11);
  end
endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        reg_we_o,
  output logic [1:0]  wb_sel_o,
  output logic        mem_we_o,
  output logic [2:0]  mem_kind_o,
  output logic [3:0]  alu_op_o,
  output logic        opa_pc_o,
  output logic        opb_imm_o,
  output logic        tgt_rs1_o,
  output logic [1:0]  pc_sel_o,
  output logic [2:0]  imm_fmt_o,
  output logic        illegal_o
);
  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;
  logic             unused_fields;
  op_class_e        cls;
  alu_op_e          alu_code;
  logic             alu_legal, alu_shift;
  logic [F3_W-1:0]  mem_kind;
  logic             mem_legal;
  ctrl_t            ctl;
  logic             legal;

  assign opc = insn_i[OPC_W-1:0];
  assign f3  = insn_i[14:12];
  assign f7  = insn_i[ILEN-1:ILEN-F7_W];
  assign unused_fields = ^{insn_i[24:15], insn_i[11:7]};

  rvdec_class u_class (.opc_i(opc), .cls_o(cls));

  rvdec_alu u_alu (
    .f3_i(f3), .f7_i(f7), .is_reg_i(cls == CL_REG),
    .op_o(alu_code), .legal_o(alu_legal), .shift_fmt_o(alu_shift)
  );

  rvdec_mem u_mem (
    .f3_i(f3), .is_store_i(cls == CL_STORE),
    .kind_o(mem_kind), .legal_o(mem_legal)
  );

  always_comb begin
    ctl   = '0;
    legal = 1'b1;
    unique case (cls)
      CL_REG: begin
        legal      = alu_legal;
        ctl.reg_we = 1'b1;
        ctl.alu_op = alu_code;
      end
      CL_IMM: begin
        legal       = alu_legal;
        ctl.reg_we  = 1'b1;
        ctl.alu_op  = alu_code;
        ctl.opb_imm = 1'b1;
        ctl.imm_fmt = alu_shift ? IMF_ISHIFT : IMF_IARITH;
      end
      CL_LOAD: begin
        legal        = mem_legal;
        ctl.reg_we   = 1'b1;
        ctl.wb_sel   = WB_MEM;
        ctl.opb_imm  = 1'b1;
        ctl.mem_kind = mem_kind;
      end
      CL_STORE: begin
        legal        = mem_legal;
        ctl.mem_we   = 1'b1;
        ctl.opb_imm  = 1'b1;
        ctl.mem_kind = mem_kind;
        ctl.imm_fmt  = IMF_S;
      end
      CL_BRANCH: begin
        legal       = (f3[2:1] != 2'b01);
        ctl.pc_sel  = PCS_BRANCH;
        ctl.imm_fmt = IMF_B;
      end
      CL_JAL: begin
        ctl.reg_we  = 1'b1;
        ctl.wb_sel  = WB_LINK;
        ctl.pc_sel  = PCS_JUMP;
        ctl.imm_fmt = IMF_J;
      end
      CL_JALR: begin
        legal       = (f3 == 3'b000);
        ctl.reg_we  = 1'b1;
        ctl.wb_sel  = WB_LINK;
        ctl.pc_sel  = PCS_JUMP;
        ctl.tgt_rs1 = 1'b1;
      end
      CL_LUI: begin
        ctl.reg_we  = 1'b1;
        ctl.alu_op  = ALU_PASSB;
        ctl.opb_imm = 1'b1;
        ctl.imm_fmt = IMF_U;
      end
      CL_AUIPC: begin
        ctl.reg_we  = 1'b1;
        ctl.opa_pc  = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.imm_fmt = IMF_U;
      end
      default: legal = 1'b0;
    endcase
    if (!legal) ctl = '0;
  end

  assign reg_we_o   = ctl.reg_we;
  assign wb_sel_o   = ctl.wb_sel;
  assign mem_we_o   = ctl.mem_we;
  assign mem_kind_o = ctl.mem_kind;
  assign alu_op_o   = ctl.alu_op;
  assign opa_pc_o   = ctl.opa_pc;
  assign opb_imm_o  = ctl.opb_imm;
  assign tgt_rs1_o  = ctl.tgt_rs1;
  assign pc_sel_o   = ctl.pc_sel;
  assign imm_fmt_o  = ctl.imm_fmt;
  assign illegal_o  = ~legal;
endmodule

// File: rtl/rvdec_top_chk.sv
module rvdec_top_chk (
  input logic [31:0] insn_i,
  input logic        reg_we_o,
  input logic [1:0]  wb_sel_o,
  input logic        mem_we_o,
  input logic [3:0]  alu_op_o,
  input logic        opa_pc_o,
  input logic        tgt_rs1_o,
  input logic [1:0]  pc_sel_o,
  input logic [2:0]  imm_fmt_o,
  input logic        illegal_o
);
  logic [6:0] opc;
  logic       known;
  logic       unused_rest;

  assign opc   = insn_i[6:0];
  assign known = (opc == 7'h33) || (opc == 7'h13) || (opc == 7'h03) ||
                 (opc == 7'h23) || (opc == 7'h63) || (opc == 7'h6F) ||
                 (opc == 7'h67) || (opc == 7'h37) || (opc == 7'h17);
  assign unused_rest = ^insn_i[31:7];

  always_comb begin
    // R1
    p_unknown_opc_r1: assert (known || illegal_o)
      else $error("unknown opcode not flagged");
    // R4
    p_illegal_quiet_r4: assert (!illegal_o || (!reg_we_o && !mem_we_o))
      else $error("illegal word writes state");
    // R5
    p_link_src_r5: assert (wb_sel_o != 2'd2 || opc == 7'h6F || opc == 7'h67)
      else $error("link writeback outside jumps");
    // R7
    p_store_branch_no_rf_r7: assert (!((opc == 7'h23) || (opc == 7'h63)) || !reg_we_o)
      else $error("store or branch writes register file");
    // R7
    p_memwe_store_only_r7: assert (!mem_we_o || (opc == 7'h23 && !illegal_o))
      else $error("memory write outside store");
    // R8
    p_lui_passb_r8: assert (opc != 7'h37 || alu_op_o == 4'd11)
      else $error("lui not pass-B");
    // R8
    p_opa_pc_auipc_r8: assert (!opa_pc_o || opc == 7'h17)
      else $error("PC on operand A outside auipc");
    // R9
    p_tgt_rs1_jalr_r9: assert (!tgt_rs1_o || opc == 7'h67)
      else $error("rs1 target base outside jalr");
    // R9
    p_pcsel_range_r9: assert (pc_sel_o != 2'd3)
      else $error("pc hint out of range");
    // R10
    p_immfmt_range_r10: assert (imm_fmt_o <= 3'd5)
      else $error("immediate format out of range");
  end
endmodule

bind rvdec_top rvdec_top_chk u_chk (
  .insn_i(insn_i), .reg_we_o(reg_we_o), .wb_sel_o(wb_sel_o),
  .mem_we_o(mem_we_o), .alu_op_o(alu_op_o), .opa_pc_o(opa_pc_o),
  .tgt_rs1_o(tgt_rs1_o), .pc_sel_o(pc_sel_o), .imm_fmt_o(imm_fmt_o),
  .illegal_o(illegal_o)
);

// File: tb/rvdec_top_bench.sv
module rvdec_top_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] insn;
  logic        reg_we, mem_we, opa_pc, opb_imm, tgt_rs1, illegal;
  logic [1:0]  wb_sel, pc_sel;
  logic [2:0]  mem_kind, imm_fmt;
  logic [3:0]  alu_op;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int e_we, e_wb, e_mwe, e_mk, e_alu, e_opa, e_opb, e_tgt, e_pcs, e_imm, e_ill;

  rvdec_top u_rvdec_top (
    .insn_i(insn), .reg_we_o(reg_we), .wb_sel_o(wb_sel), .mem_we_o(mem_we),
    .mem_kind_o(mem_kind), .alu_op_o(alu_op), .opa_pc_o(opa_pc),
    .opb_imm_o(opb_imm), .tgt_rs1_o(tgt_rs1), .pc_sel_o(pc_sel),
    .imm_fmt_o(imm_fmt), .illegal_o(illegal)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s insn=%08h actual=%0d expected=%0d", tag, what, insn, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, output bit known);
    int opc, f3, f7;
    bit ok;
    opc = int'(w[6:0]);
    f3  = int'(w[14:12]);
    f7  = int'(w[31:25]);
    e_we = 0; e_wb = 0; e_mwe = 0; e_mk = 0; e_alu = 0; e_opa = 0;
    e_opb = 0; e_tgt = 0; e_pcs = 0; e_imm = 0;
    ok = 1; known = 1;
    case (opc)
      'h33: begin
        ok = (f7 == 0) || (f7 == 32 && (f3 == 0 || f3 == 5));
        e_we = 1;
        e_alu = (f7 == 32) ? ((f3 == 0) ? 8 : 9) : f3;
      end
      'h13: begin
        if (f3 == 1) ok = (f7 == 0);
        if (f3 == 5) ok = (f7 == 0) || (f7 == 32);
        e_we = 1; e_opb = 1;
        e_alu = (f3 == 5 && f7 == 32) ? 9 : f3;
        e_imm = (f3 == 1 || f3 == 5) ? 1 : 0;
      end
      'h03: begin
        ok = (f3 <= 2) || (f3 == 4) || (f3 == 5);
        e_we = 1; e_wb = 1; e_opb = 1; e_mk = f3;
      end
      'h23: begin
        ok = (f3 <= 2);
        e_mwe = 1; e_opb = 1; e_mk = f3; e_imm = 2;
      end
      'h63: begin
        ok = (f3 != 2) && (f3 != 3);
        e_pcs = 2; e_imm = 3;
      end
      'h6F: begin e_we = 1; e_wb = 2; e_pcs = 1; e_imm = 4; end
      'h67: begin
        ok = (f3 == 0);
        e_we = 1; e_wb = 2; e_pcs = 1; e_tgt = 1;
      end
      'h37: begin e_we = 1; e_alu = 11; e_opb = 1; e_imm = 5; end
      'h17: begin e_we = 1; e_opa = 1; e_opb = 1; e_imm = 5; end
      default: begin ok = 0; known = 0; end
    endcase
    e_ill = ok ? 0 : 1;
    if (!ok) begin
      e_we = 0; e_wb = 0; e_mwe = 0; e_mk = 0; e_alu = 0; e_opa = 0;
      e_opb = 0; e_tgt = 0; e_pcs = 0; e_imm = 0;
    end
  endtask

  task automatic compare_all(bit known);
    string t_ill, t_we, t_alu, t_unused;
    int opc;
    opc = int'(insn[6:0]);
    t_ill    = known ? "R4" : "R1";
    t_we     = e_ill ? "R4" : "R7";
    t_alu    = e_ill ? "R4" : (opc == 'h13) ? "R3" : (opc == 'h37 || opc == 'h17) ? "R8" : "R2";
    t_unused = e_ill ? "R4" : "R11";
    check(t_ill, "illegal", int'(illegal), e_ill);
    check(t_we, "reg_we", int'(reg_we), e_we);
    check(t_we, "mem_we", int'(mem_we), e_mwe);
    check(e_ill ? "R4" : "R5", "wb_sel", int'(wb_sel), e_wb);
    check(e_ill ? "R4" : "R6", "mem_kind", int'(mem_kind), e_mk);
    check(t_alu, "alu_op", int'(alu_op), e_alu);
    check(e_ill ? "R4" : "R8", "opa_pc", int'(opa_pc), e_opa);
    check(t_unused, "opb_imm", int'(opb_imm), e_opb);
    check(e_ill ? "R4" : "R9", "tgt_rs1", int'(tgt_rs1), e_tgt);
    check(e_ill ? "R4" : "R9", "pc_sel", int'(pc_sel), e_pcs);
    check(e_ill ? "R4" : "R10", "imm_fmt", int'(imm_fmt), e_imm);
  endtask

  task automatic apply(input logic [31:0] w);
    bit known;
    @(posedge clk);
    insn = w;
    @(negedge clk);
    model(w, known);
    compare_all(known);
  endtask

  initial begin
    logic [6:0] f7_set [6];
    f7_set[0] = 7'b0000000; f7_set[1] = 7'b0100000; f7_set[2] = 7'b0000001;
    f7_set[3] = 7'b1000000; f7_set[4] = 7'b0100001; f7_set[5] = 7'b1111111;
    rst_n = 1'b0;
    insn  = 32'h0000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state with an all-zero word: unknown opcode, nothing written (R1, R4)
    check("R1", "reset illegal", int'(illegal), 1);
    check("R4", "reset reg_we", int'(reg_we), 0);
    check("R4", "reset mem_we", int'(mem_we), 0);
    rst_n = 1'b1;

    // Named corner words
    apply(32'h4000_D0B3);  // sra: R2 code 9
    apply(32'h4000_00B3);  // sub: R2 code 8
    apply(32'h4000_20B3);  // funct7 alt on slt: R4
    apply(32'h4000_0093);  // addi with bit30 set: R3 stays add
    apply(32'h4000_1093);  // slli with alt funct7: R4
    apply(32'h0000_6083);  // load funct3 110: R4 / R6
    apply(32'h0000_3023);  // store funct3 011: R4
    apply(32'h0000_1067);  // jalr funct3 001: R4 / R9
    apply(32'hFFFF_F0B7);  // lui: R8
    apply(32'h0000_1097);  // auipc: R8

    // Sweep: every opcode x funct3 x funct7 set, index fields varied
    for (int opc = 0; opc < 128; opc++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int k = 0; k < 6; k++) begin
          logic [14:0] filler;
          filler = 15'(opc * 37 + f3 * 911 + k * 4099);
          apply({f7_set[k], filler[14:5], 3'(f3), filler[4:0], 7'(opc)});
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule